// File: doc/BRIEF.md
# Synchronous Serial Frame Master Receiver

This block is the clock-owning end of a one-way synchronous serial link. The far end is a serial port on a signal processor that only transmits. The block divides the system clock down to a serial bit clock and issues an active-high frame sync one bit period wide. It then collects the incoming data line into 16-bit words. A frame is a single phase of 20 words. The sender only transmits when the block clocks it and marks the frame start.

The data delay is zero: the bit period that carries the frame sync also carries the most significant bit of word 0. The sender changes its data just after each rising edge of the bit clock. The receiver therefore samples at the falling edge, which is mid-bit. Timing comes from enables derived inside the system clock domain; the bit clock is never used as a clock inside the block.

Each completed word is presented for one system cycle, together with its position in the frame. The last word of a frame also raises an end-of-frame flag. Words are handed over exactly in the order they were sent. If the sender's first word is stale or zero, it still appears at position 0 and is never dropped. Between frames the block runs a configurable number of idle bit periods, during which the data line is ignored.

Top module: `frame_master_rx`

## Requirements
- R1: While `rst` is high, `sclk_o`, `fsync_o`, `word_vld_o` and `frame_done_o` are all low from the first clock edge onward.
- R2: After `rst` falls, `fsync_o` first goes high at the (IDLE_BITS*CLK_DIV+1)-th rising edge of `clk`. This leaves one full idle gap of IDLE_BITS bit periods.
- R3: Every bit period lasts CLK_DIV system cycles and starts with a rising edge of `sclk_o`. `sclk_o` then stays high for floor(CLK_DIV/2) cycles and low for the rest of the period.
- R4: `fsync_o` is active high for exactly one bit period (CLK_DIV cycles). It rises and falls only in cycles where `sclk_o` rises.
- R5: Data delay is zero and words are shifted in MSB first. The bit sampled in the fsync bit period is bit 15 of word 0, and each bit is sampled on the falling edge of `sclk_o`.
- R6: Each frame delivers exactly FRAME_WORDS (20) words. `word_vld_o` is a one-cycle pulse per word, and `word_idx_o` counts 0,1,...,19 in order within the frame.
- R7: `frame_done_o` is high exactly in the cycle where `word_vld_o` is high with `word_idx_o` = 19, and at no other time.
- R8: Consecutive frame syncs are (FRAME_WORDS*WORD_BITS + IDLE_BITS)*CLK_DIV cycles apart. The data line is ignored during the idle bits, so no `word_vld_o` occurs there.
- R9: The word aligned to the frame sync is delivered at index 0 even when it is zero or repeats the previous frame's last word.
- R10: A reset during a frame abandons that frame. No word from it is delivered after release, and the next frame starts after a full idle gap with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_i | input | 1 | Serial data from the far end |
| sclk_o | output | 1 | Generated serial bit clock |
| fsync_o | output | 1 | Frame sync, active high, one bit period |
| word_vld_o | output | 1 | One-cycle strobe for a completed word |
| word_o | output | WORD_BITS (16) | Received word, MSB first on the line |
| word_idx_o | output | clog2(FRAME_WORDS) (5) | Position of the word in its frame, 0 to 19 |
| frame_done_o | output | 1 | High with the strobe of the last word of a frame |

## Verification
The bench plays the part of the sender. It drives each bit just after every rising edge of the bit clock and restarts at word 0 whenever it sees the sync on that edge. A receiver that adds one bit of delay, or that samples on the rising edge, would return every word shifted by one bit. This shows up on the alternating all-ones and all-zeros words and on the lone-MSB and lone-LSB words. A receiver that treats the sync cycle as a lead-in would lose the zero or stale word 0 and shift every index by one. In that case index 19 would never carry the done flag. The bench also measures the idle gap after reset, the sync width and the frame period, and it holds the data line high while idle, so a miscounted gap or a receiver that shifts during idle produces wrong timing or stray strobes. It also pulses reset in the middle of a frame: it expects no stray word afterwards and a clean restart at index 0.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

  // Per-cycle timing strobes derived from the bit clock divider.
  typedef struct packed {
    logic bit_end;   // last system cycle of the current bit period
    logic sample;    // cycle in which the bit clock has just fallen
  } fmr_tick_t;

endpackage

// File: rtl/fmr_clkgen.sv
module fmr_clkgen
  import fmr_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  output logic      sclk_o,
  output fmr_tick_t tick_o
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HIGH_LEN = CW'(CLK_DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          sclk_q;

  // The count parks on its last value during reset, so the first edge
  // after release opens a fresh bit period with a rising clock.
  always_comb begin
    if (cnt_q == LAST_CNT) cnt_nxt = '0;
    else                   cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LAST_CNT;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      sclk_q <= (cnt_nxt < HIGH_LEN);
    end
  end

  assign sclk_o         = sclk_q;
  assign tick_o.bit_end = (cnt_q == LAST_CNT);
  assign tick_o.sample  = (cnt_q == HIGH_LEN);

endmodule

// File: rtl/fmr_sequencer.sv
module fmr_sequencer #(
  parameter int WORD_BITS   = 16,
  parameter int FRAME_WORDS = 20,
  parameter int IDLE_BITS   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bit_end_i,
  output logic                           fsync_o,
  output logic                           in_frame_o,
  output logic                           last_bit_o,
  output logic                           last_word_o,
  output logic [$clog2(FRAME_WORDS)-1:0] word_idx_o
);

  localparam int BW = $clog2(WORD_BITS);
  localparam int XW = $clog2(FRAME_WORDS);
  localparam int IW = $clog2(IDLE_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_BITS - 1);
  localparam logic [XW-1:0] LAST_WORD = XW'(FRAME_WORDS - 1);
  localparam logic [IW-1:0] IDLE_FULL = IW'(IDLE_BITS);
  localparam logic [IW-1:0] IDLE_REST = IW'(IDLE_BITS - 1);

  logic          in_frame_q;
  logic          fsync_q;
  logic [BW-1:0] bit_q;
  logic [XW-1:0] word_q;
  logic [IW-1:0] idle_left_q;

  // State describes the bit period that is currently on the line; it
  // advances on the last system cycle of each period.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q  <= 1'b0;
      fsync_q     <= 1'b0;
      bit_q       <= '0;
      word_q      <= '0;
      idle_left_q <= IDLE_FULL;
    end else if (bit_end_i) begin
      if (in_frame_q) begin
        fsync_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          bit_q <= '0;
          if (word_q == LAST_WORD) begin
            in_frame_q  <= 1'b0;
            idle_left_q <= IDLE_REST;
          end else begin
            word_q <= word_q + 1'b1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        if (idle_left_q == '0) begin
          in_frame_q <= 1'b1;
          fsync_q    <= 1'b1;
          bit_q      <= '0;
          word_q     <= '0;
        end else begin
          idle_left_q <= idle_left_q - 1'b1;
        end
      end
    end
  end

  assign fsync_o     = fsync_q;
  assign in_frame_o  = in_frame_q;
  assign last_bit_o  = (bit_q == LAST_BIT);
  assign last_word_o = (word_q == LAST_WORD);
  assign word_idx_o  = word_q;

endmodule

// File: rtl/fmr_shifter.sv
module fmr_shifter #(
  parameter int WORD_BITS   = 16,
  parameter int FRAME_WORDS = 20
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sample_i,
  input  logic                           in_frame_i,
  input  logic                           last_bit_i,
  input  logic                           last_word_i,
  input  logic [$clog2(FRAME_WORDS)-1:0] word_idx_i,
  input  logic                           sd_i,
  output logic [WORD_BITS-1:0]           word_o,
  output logic [$clog2(FRAME_WORDS)-1:0] word_idx_o,
  output logic                           word_vld_o,
  output logic                           frame_done_o
);

  localparam int XW = $clog2(FRAME_WORDS);

  logic [WORD_BITS-1:0] shift_q;
  logic [WORD_BITS-1:0] shift_nxt;
  logic [WORD_BITS-1:0] word_q;
  logic [XW-1:0]        idx_q;
  logic                 vld_q;
  logic                 done_q;

  // MSB arrives first, so each new bit enters at the bottom.
  assign shift_nxt = {shift_q[WORD_BITS-2:0], sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      word_q  <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (sample_i && in_frame_i) begin
        shift_q <= shift_nxt;
        if (last_bit_i) begin
          word_q <= shift_nxt;
          idx_q  <= word_idx_i;
          vld_q  <= 1'b1;
          done_q <= last_word_i;
        end
      end
    end
  end

  assign word_o       = word_q;
  assign word_idx_o   = idx_q;
  assign word_vld_o   = vld_q;
  assign frame_done_o = done_q;

endmodule

// File: rtl/frame_master_rx.sv
module frame_master_rx #(
  parameter int WORD_BITS   = 16,
  parameter int FRAME_WORDS = 20,
  parameter int CLK_DIV     = 4,
  parameter int IDLE_BITS   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sd_i,
  output logic                           sclk_o,
  output logic                           fsync_o,
  output logic                           word_vld_o,
  output logic [WORD_BITS-1:0]           word_o,
  output logic [$clog2(FRAME_WORDS)-1:0] word_idx_o,
  output logic                           frame_done_o
);

  import fmr_pkg::*;

  localparam int XW = $clog2(FRAME_WORDS);

  fmr_tick_t     tick;
  logic          in_frame;
  logic          last_bit;
  logic          last_word;
  logic [XW-1:0] seq_idx;

  fmr_clkgen #(
    .CLK_DIV (CLK_DIV)
  ) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .sclk_o (sclk_o),
    .tick_o (tick)
  );

  fmr_sequencer #(
    .WORD_BITS   (WORD_BITS),
    .FRAME_WORDS (FRAME_WORDS),
    .IDLE_BITS   (IDLE_BITS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .bit_end_i   (tick.bit_end),
    .fsync_o     (fsync_o),
    .in_frame_o  (in_frame),
    .last_bit_o  (last_bit),
    .last_word_o (last_word),
    .word_idx_o  (seq_idx)
  );

  fmr_shifter #(
    .WORD_BITS   (WORD_BITS),
    .FRAME_WORDS (FRAME_WORDS)
  ) u_shift (
    .clk          (clk),
    .rst          (rst),
    .sample_i     (tick.sample),
    .in_frame_i   (in_frame),
    .last_bit_i   (last_bit),
    .last_word_i  (last_word),
    .word_idx_i   (seq_idx),
    .sd_i         (sd_i),
    .word_o       (word_o),
    .word_idx_o   (word_idx_o),
    .word_vld_o   (word_vld_o),
    .frame_done_o (frame_done_o)
  );

endmodule

// File: rtl/fmr_checks.sv
module fmr_checks #(
  parameter int FRAME_WORDS = 20,
  parameter int CLK_DIV     = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           sclk_o,
  input logic                           fsync_o,
  input logic                           word_vld_o,
  input logic [$clog2(FRAME_WORDS)-1:0] word_idx_o,
  input logic                           frame_done_o
);

  localparam int XW = $clog2(FRAME_WORDS);
  localparam int HW = $clog2(CLK_DIV + 1) + 1;
  localparam logic [XW-1:0] LAST_IDX = XW'(FRAME_WORDS - 1);
  localparam logic [HW-1:0] HIGH_LEN = HW'(CLK_DIV / 2);

  logic          rst_q;
  logic [XW-1:0] last_idx_q;
  logic [HW-1:0] hi_run_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      last_idx_q <= '0;
      hi_run_q   <= '0;
    end else begin
      if (word_vld_o) last_idx_q <= word_idx_o;
      if (sclk_o) hi_run_q <= hi_run_q + 1'b1;
      else        hi_run_q <= '0;
    end
  end

  // R1: outputs quiet once a reset edge has been taken
  always_ff @(posedge clk) begin
    if (rst_q) begin
      a_reset_quiet_r1: assert (!sclk_o && !fsync_o && !word_vld_o && !frame_done_o)
        else $error("outputs active during reset");
    end
  end

  p_sclk_high_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (hi_run_q == HIGH_LEN));

  p_fs_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_o) |-> $rose(sclk_o));

  p_fs_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fsync_o) |-> $rose(sclk_o));

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> (word_idx_o <= LAST_IDX));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    (word_vld_o && (word_idx_o != '0)) |-> (word_idx_o == last_idx_q + 1'b1));

  p_done_last_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> (word_vld_o && (word_idx_o == LAST_IDX)));

  p_last_done_r7: assert property (@(posedge clk) disable iff (rst)
    (word_vld_o && (word_idx_o == LAST_IDX)) |-> frame_done_o);

endmodule

bind frame_master_rx fmr_checks #(
  .FRAME_WORDS (FRAME_WORDS),
  .CLK_DIV     (CLK_DIV)
) u_fmr_checks (
  .clk          (clk),
  .rst          (rst),
  .sclk_o       (sclk_o),
  .fsync_o      (fsync_o),
  .word_vld_o   (word_vld_o),
  .word_idx_o   (word_idx_o),
  .frame_done_o (frame_done_o)
);

// File: tb/sim_frame_master_rx.sv
`timescale 1ns/1ps
module sim_frame_master_rx;

  localparam int CLK_PERIOD = 10;
  localparam int WB     = 16;
  localparam int NW     = 20;
  localparam int DIV    = 4;
  localparam int IDLE   = 3;
  localparam int XW     = $clog2(NW);
  localparam int PERIOD = (NW * WB + IDLE) * DIV;
  localparam int FIRST_SYNC = IDLE * DIV + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sd  = 1'b1;
  logic          sclk_o;
  logic          fsync_o;
  logic          word_vld_o;
  logic [WB-1:0] word_o;
  logic [XW-1:0] word_idx_o;
  logic          frame_done_o;

  logic [WB-1:0] tx [NW];

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cyc    = 0;
  int  prev_rise = -1;
  bit  at_sync = 1'b0;
  bit  ended   = 1'b0;

  frame_master_rx #(
    .WORD_BITS   (WB),
    .FRAME_WORDS (NW),
    .CLK_DIV     (DIV),
    .IDLE_BITS   (IDLE)
  ) u0 (
    .clk          (clk),
    .rst          (rst),
    .sd_i         (sd),
    .sclk_o       (sclk_o),
    .fsync_o      (fsync_o),
    .word_vld_o   (word_vld_o),
    .word_o       (word_o),
    .word_idx_o   (word_idx_o),
    .frame_done_o (frame_done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Sender model: drives a new bit after each rising bit clock edge and
  // restarts at word 0 when the sync is high on that edge (zero delay).
  initial begin
    int dw;
    int db;
    bit act;
    dw = 0; db = 0; act = 1'b0;
    forever begin
      @(posedge sclk_o);
      #1;
      if (fsync_o) begin dw = 0; db = 0; act = 1'b1; end
      if (act) begin
        sd = tx[dw][WB-1-db];
        if (db == WB-1) begin
          db = 0;
          if (dw == NW-1) act = 1'b0;
          else dw = dw + 1;
        end else begin
          db = db + 1;
        end
      end else begin
        sd = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Waits for a sync (unless already on one) and checks one full frame.
  task automatic run_frame();
    logic [WB-1:0] exp_w [NW];
    int  stray, n, got, fsw, per, hi, bad_done, rise;
    bit  prevf, fopen, psclk;
    for (int i = 0; i < NW; i++) exp_w[i] = tx[i];
    if (!at_sync) begin
      stray = 0; n = 0; prevf = fsync_o;
      while (n < 2 * PERIOD) begin
        @(negedge clk);
        n++;
        if (word_vld_o) stray++;
        if (fsync_o && !prevf) break;
        prevf = fsync_o;
      end
      check(stray == 0, "R8", "strobes during idle gap", stray, 0);
    end
    at_sync = 1'b0;
    rise = cyc;
    if (prev_rise >= 0)
      check(rise - prev_rise == PERIOD, "R8", "sync to sync cycles", rise - prev_rise, PERIOD);
    prev_rise = rise;
    got = 0; fsw = 1; fopen = 1'b1; psclk = 1'b1; per = -1; hi = -1; bad_done = 0; n = 0;
    while (got < NW && n < 2 * PERIOD) begin
      @(negedge clk);
      n++;
      if (fopen) begin
        if (fsync_o) fsw++;
        else fopen = 1'b0;
      end
      if (sclk_o && !psclk && per < 0) per = cyc - rise;
      if (!sclk_o && psclk && hi < 0) hi = cyc - rise;
      psclk = sclk_o;
      if (frame_done_o && !word_vld_o) bad_done++;
      if (word_vld_o) begin
        check(int'(word_idx_o) == got, "R6", "word index", int'(word_idx_o), got);
        check(word_o == exp_w[got], (got == 0) ? "R9" : "R5", "word value",
              int'(word_o), int'(exp_w[got]));
        check(frame_done_o == (got == NW-1), "R7", "frame done flag",
              int'(frame_done_o), int'(got == NW-1));
        got++;
      end
    end
    check(got == NW, "R6", "words in frame", got, NW);
    check(fsw == DIV, "R4", "sync width cycles", fsw, DIV);
    check(per == DIV, "R3", "bit period cycles", per, DIV);
    check(hi == DIV/2, "R3", "clock high cycles", hi, DIV/2);
    check(bad_done == 0, "R7", "done without strobe", bad_done, 0);
  endtask

  task automatic t_reset_start();
    int n;
    for (int i = 0; i < NW; i++) tx[i] = WB'(16'h0100 * i + i);
    repeat (4) begin
      @(negedge clk);
      check(!sclk_o && !fsync_o && !word_vld_o && !frame_done_o, "R1",
            "outputs in reset", int'({sclk_o, fsync_o, word_vld_o, frame_done_o}), 0);
    end
    rst = 1'b0;
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (fsync_o) break;
    end
    check(n == FIRST_SYNC, "R2", "edges to first sync", n, FIRST_SYNC);
    at_sync = 1'b1;
    run_frame();
  endtask

  task automatic t_ramp();
    for (int i = 0; i < NW; i++) tx[i] = WB'((i * 16'h0B3D) ^ 16'h5A5A);
    run_frame();
  endtask

  task automatic t_edges_r5();
    for (int i = 0; i < NW; i++) begin
      case (i % 4)
        0: tx[i] = 16'h0000;
        1: tx[i] = 16'hFFFF;
        2: tx[i] = 16'h8000;
        default: tx[i] = 16'h0001;
      endcase
    end
    run_frame();
  endtask

  task automatic t_stale_lead_r9();
    logic [WB-1:0] prev_last;
    prev_last = tx[NW-1];
    for (int i = 1; i < NW; i++) tx[i] = WB'(16'hC3A0 + i);
    tx[0] = prev_last;
    run_frame();
    tx[0] = 16'h0000;
    for (int i = 1; i < NW; i++) tx[i] = WB'(16'h7E00 | i);
    run_frame();
  endtask

  task automatic t_reset_mid_r10();
    int n, stray;
    bit prevf;
    prevf = fsync_o;
    n = 0;
    while (n < 2 * PERIOD) begin
      @(negedge clk);
      n++;
      if (fsync_o && !prevf) break;
      prevf = fsync_o;
    end
    repeat (200) @(negedge clk);
    rst = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(!sclk_o && !fsync_o && !word_vld_o && !frame_done_o, "R1",
            "outputs in mid-frame reset", int'({sclk_o, fsync_o, word_vld_o, frame_done_o}), 0);
    end
    for (int i = 0; i < NW; i++) tx[i] = WB'(16'hA000 + 16'h0111 * i);
    rst = 1'b0;
    prev_rise = -1;
    n = 0; stray = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (word_vld_o) stray++;
      if (fsync_o) break;
    end
    check(n == FIRST_SYNC, "R10", "edges to sync after abort", n, FIRST_SYNC);
    check(stray == 0, "R10", "strobes from abandoned frame", stray, 0);
    at_sync = 1'b1;
    run_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_start();
    t_ramp();
    t_edges_r5();
    t_stale_lead_r9();
    t_reset_mid_r10();
    t_ramp();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule